// File: doc/BRIEF.md
# Path Overhead Byte Source Selector

This block produces the nine path overhead byte slots of each outgoing payload envelope. The slots come in a fixed order: trace, parity, signal label, status, user channel, multiframe indicator, two growth bytes and the tandem byte. For the last four slots (indexes 5 to 8), a per-byte select bit chooses where the byte comes from. It is either a host-written value register or a bit-serial overhead port that an external circuit drives. The pointer and parity stages downstream fill slots 0 to 4, so the block emits them as 0x00 placeholders.

A start-of-frame pulse begins one overhead sequence. The sequence runs 9 slots × 8 bits, and each bit period lasts two system clocks. During the sequence the block drives the port clock, an enable strobe and a frame strobe. The external circuit changes its data while the port clock is low, and the block latches each bit when the clock rises. The block shifts each byte into a staging register and releases it on the byte output only when its slot closes, together with the slot index.

Host writes land in working registers. The block copies them into a frame copy at each accepted start of frame, so every sequence uses one consistent configuration.

Top module: `poh_ins_sel`

## Requirements
- R1: After reset, poh_clk, poh_en, poh_frm and oh_valid are low. All select bits and value registers are zero, so a frame started before any write emits 0x00 in every slot.
- R2: Writing wr_addr 0 loads the select bits from wr_data[3:0]. Bit 3 picks the source of slot 5, bit 2 slot 6, bit 1 slot 7 and bit 0 slot 8. A 0 bit means the slot takes its value register. wr_addr 1, 2, 3 and 4 write the value registers of slots 5, 6, 7 and 8. Other addresses change nothing.
- R3: A select bit of 1 makes the slot's byte the eight bits latched from poh_din during that slot's eight bit periods. The first bit latched is the most significant.
- R4: While a sequence runs, poh_clk is low for one clock and high for the next, starting low on the clock after the start is accepted. poh_din is latched at each low-to-high step.
- R5: poh_en is high for exactly 144 clocks from the accepted start. poh_frm is high only during the first bit period (the first 2 clocks), and only while poh_en is high.
- R6: Slot s is presented for exactly one clock, with oh_valid high and oh_idx = s, 16·(s+1) clocks after the accepted start. Slots 0 to 4 carry 0x00.
- R7: A register write affects only sequences whose start is accepted after the write. A write during a sequence leaves that sequence's bytes unchanged.
- R8: A sof pulse while a sequence is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame pulse; begins an overhead sequence |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 3 | Register select: 0 select bits, 1..4 value registers of slots 5..8 |
| wr_data | input | 8 | Host write data |
| poh_din | input | 1 | Serial overhead data from the external circuit |
| poh_clk | output | 1 | Serial port clock (system clock / 2 during a sequence) |
| poh_en | output | 1 | High while the overhead sequence runs |
| poh_frm | output | 1 | High during the first bit period of the sequence |
| oh_valid | output | 1 | One-clock strobe: an overhead byte is presented |
| oh_idx | output | 4 | Slot index of the presented byte (0..8) |
| oh_byte | output | 8 | Presented overhead byte |

## Verification
The bench uses the default parameters: 8-bit bytes, nine slots, and the selectable run starting at slot 5. With these values a full sequence takes only 144 clocks, so several whole frames fit in one run. Those frames cover every select pattern of interest: all software, all serial, and two mixed patterns. Between frames, the serial data changes with a frame number. A stray sof and a configuration write land in the middle of a sequence, which brings the frame-copy boundary and the ignored restart within reach.

// File: rtl/poh_pkg.sv
package poh_pkg;
  localparam int unsigned ADDR_W    = 3;
  localparam logic [ADDR_W-1:0] ADDR_SEL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_VAL0 = 3'd1;
  localparam int unsigned CLKS_PER_BIT = 2;
endpackage

// File: rtl/poh_regs.sv
module poh_regs #(
  parameter int unsigned BYTE_W  = 8,
  parameter int unsigned NUM_SEL = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [poh_pkg::ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       load,
  output logic [NUM_SEL-1:0]         fr_sel,
  output logic [NUM_SEL*BYTE_W-1:0]  fr_val
);
  import poh_pkg::*;

  logic [NUM_SEL-1:0]        wk_sel;
  logic [NUM_SEL*BYTE_W-1:0] wk_val;

  // select bits: data bit (NUM_SEL-1-i) governs selectable slot i
  always_ff @(posedge clk) begin
    if (rst) begin
      wk_sel <= '0;
    end else if (wr_en && wr_addr == ADDR_SEL) begin
      for (int i = 0; i < NUM_SEL; i++) wk_sel[i] <= wr_data[NUM_SEL-1-i];
    end
  end

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_val
    always_ff @(posedge clk) begin
      if (rst) begin
        wk_val[g*BYTE_W +: BYTE_W] <= '0;
      end else if (wr_en && wr_addr == ADDR_VAL0 + ADDR_W'(g)) begin
        wk_val[g*BYTE_W +: BYTE_W] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fr_sel <= '0;
      fr_val <= '0;
    end else if (load) begin
      fr_sel <= wk_sel;
      fr_val <= wk_val;
    end
  end
endmodule

// File: rtl/poh_timing.sv
module poh_timing #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_SLOTS = 9,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS),
  localparam int unsigned BIT_W    = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sof,
  output logic              load,
  output logic              rise,
  output logic              byte_done,
  output logic [SLOT_W-1:0] slot,
  output logic              poh_clk,
  output logic              poh_en,
  output logic              poh_frm
);
  logic             active;
  logic             ph;
  logic [BIT_W-1:0] bit_cnt;

  assign load      = sof && !active;
  assign rise      = active && !ph;
  assign byte_done = active && ph && (bit_cnt == BIT_W'(BYTE_W-1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      ph      <= 1'b0;
      bit_cnt <= '0;
      slot    <= '0;
      poh_clk <= 1'b0;
      poh_en  <= 1'b0;
      poh_frm <= 1'b0;
    end else if (load) begin
      active  <= 1'b1;
      ph      <= 1'b0;
      bit_cnt <= '0;
      slot    <= '0;
      poh_clk <= 1'b0;
      poh_en  <= 1'b1;
      poh_frm <= 1'b1;
    end else if (active) begin
      ph      <= !ph;
      poh_clk <= !ph;
      if (ph) begin
        poh_frm <= 1'b0;
        bit_cnt <= bit_cnt + 1'b1;
        if (bit_cnt == BIT_W'(BYTE_W-1)) begin
          bit_cnt <= '0;
          if (slot == SLOT_W'(NUM_SLOTS-1)) begin
            active  <= 1'b0;
            poh_en  <= 1'b0;
            poh_clk <= 1'b0;
            slot    <= '0;
          end else begin
            slot <= slot + 1'b1;
          end
        end
      end
    end
  end

  // R5
  frm_in_en_chk: assert property (@(posedge clk) disable iff (rst)
    poh_frm |-> poh_en);

  // R4
  clk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (poh_en && $past(poh_en)) |-> (poh_clk != $past(poh_clk)));
endmodule

// File: rtl/poh_capture.sv
module poh_capture #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned FIRST_SEL = 5,
  localparam int unsigned NUM_SEL  = NUM_SLOTS - FIRST_SEL,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      rise,
  input  logic                      din,
  input  logic                      byte_done,
  input  logic [SLOT_W-1:0]         slot,
  input  logic [NUM_SEL-1:0]        fr_sel,
  input  logic [NUM_SEL*BYTE_W-1:0] fr_val,
  output logic                      out_valid,
  output logic [SLOT_W-1:0]         out_idx,
  output logic [BYTE_W-1:0]         out_byte
);
  logic [BYTE_W-1:0] stage;
  logic [BYTE_W-1:0] pick;

  always_ff @(posedge clk) begin
    if (rst) stage <= '0;
    else if (rise) stage <= {stage[BYTE_W-2:0], din};
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NUM_SEL; i++) begin
      if (slot == SLOT_W'(FIRST_SEL + i))
        pick = fr_sel[i] ? stage : fr_val[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= byte_done;
      if (byte_done) begin
        out_idx  <= slot;
        out_byte <= pick;
      end
    end
  end

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R6
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_idx < SLOT_W'(NUM_SLOTS)));
endmodule

// File: rtl/poh_ins_sel.sv
module poh_ins_sel #(
  parameter int unsigned BYTE_W    = 8,
  parameter int unsigned NUM_SLOTS = 9,
  parameter int unsigned FIRST_SEL = 5,
  localparam int unsigned NUM_SEL  = NUM_SLOTS - FIRST_SEL,
  localparam int unsigned SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       sof,
  input  logic                       wr_en,
  input  logic [poh_pkg::ADDR_W-1:0] wr_addr,
  input  logic [BYTE_W-1:0]          wr_data,
  input  logic                       poh_din,
  output logic                       poh_clk,
  output logic                       poh_en,
  output logic                       poh_frm,
  output logic                       oh_valid,
  output logic [SLOT_W-1:0]          oh_idx,
  output logic [BYTE_W-1:0]          oh_byte
);
  logic                      load, rise, byte_done;
  logic [SLOT_W-1:0]         slot;
  logic [NUM_SEL-1:0]        fr_sel;
  logic [NUM_SEL*BYTE_W-1:0] fr_val;

  poh_regs #(.BYTE_W(BYTE_W), .NUM_SEL(NUM_SEL)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .fr_sel(fr_sel), .fr_val(fr_val));

  poh_timing #(.BYTE_W(BYTE_W), .NUM_SLOTS(NUM_SLOTS)) i_timing (
    .clk(clk), .rst(rst), .sof(sof), .load(load), .rise(rise),
    .byte_done(byte_done), .slot(slot), .poh_clk(poh_clk),
    .poh_en(poh_en), .poh_frm(poh_frm));

  poh_capture #(.BYTE_W(BYTE_W), .NUM_SLOTS(NUM_SLOTS), .FIRST_SEL(FIRST_SEL)) i_cap (
    .clk(clk), .rst(rst), .rise(rise), .din(poh_din), .byte_done(byte_done),
    .slot(slot), .fr_sel(fr_sel), .fr_val(fr_val), .out_valid(oh_valid),
    .out_idx(oh_idx), .out_byte(oh_byte));

  // R6
  valid_in_seq_chk: assert property (@(posedge clk) disable iff (rst)
    oh_valid |-> $past(poh_en));
endmodule

// File: tb/test_poh_ins_sel.sv
module test_poh_ins_sel;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sof = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       poh_din = 1'b0;
  logic       poh_clk, poh_en, poh_frm, oh_valid;
  logic [3:0] oh_idx;
  logic [7:0] oh_byte;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  poh_ins_sel i_poh_ins_sel (
    .clk(clk), .rst(rst), .sof(sof), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .poh_din(poh_din), .poh_clk(poh_clk), .poh_en(poh_en),
    .poh_frm(poh_frm), .oh_valid(oh_valid), .oh_idx(oh_idx), .oh_byte(oh_byte));

  // behavioural reference
  int       k = 0;
  int       fr = 0;
  bit       m_act = 0;
  bit [3:0] w_sel = 0, s_sel = 0;     // w_sel[3]=slot5 ... w_sel[0]=slot8
  bit [7:0] w_val [4];
  bit [7:0] s_val [4];
  bit       e_valid = 0;
  int       e_idx = 0;
  bit [7:0] e_byte = 0;

  function automatic bit [7:0] ser_byte(int f, int s);
    return 8'((f * 53 + s * 29 + 8'h5A) & 8'hFF);
  endfunction

  always @(posedge clk) begin
    e_valid = 0;
    if (rst) begin
      m_act = 0; k = 0; w_sel = 0; s_sel = 0;
      for (int i = 0; i < 4; i++) begin w_val[i] = 0; s_val[i] = 0; end
    end else begin
      if (m_act) begin
        k++;
        if (k % 16 == 0) begin
          int s;
          s = k / 16 - 1;
          e_valid = 1; e_idx = s;
          if (s < 5) e_byte = 8'h00;
          else if (s_sel[8 - s]) e_byte = ser_byte(fr, s);
          else e_byte = s_val[s - 5];
        end
        if (k == 144) m_act = 0;
      end else if (sof) begin
        m_act = 1; k = 0; fr++;
        s_sel = w_sel;
        for (int i = 0; i < 4; i++) s_val[i] = w_val[i];
      end
      if (wr_en) begin
        if (wr_addr == 0) w_sel = wr_data[3:0];
        else if (wr_addr >= 1 && wr_addr <= 4) w_val[wr_addr - 1] = wr_data;
      end
    end
  end

  task automatic chk(string tag, string what, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s got %0h exp %0h (k=%0d)", tag, what, got, exp, k);
    end
  endtask

  // drive serial data while poh_clk is low, compare every clock
  always @(negedge clk) begin
    if (!rst) begin
      if (m_act && (k % 2 == 0) && k < 144) begin
        int b;
        b = k / 2;
        poh_din <= ser_byte(fr, b / 8)[7 - (b % 8)];
      end
      chk("R5", "poh_en", poh_en, m_act);
      chk("R4", "poh_clk", poh_clk, m_act ? (k % 2) : 0);
      chk("R5", "poh_frm", poh_frm, m_act && k < 2);
      chk("R6", "oh_valid", oh_valid, e_valid);
      if (e_valid && oh_valid) begin
        chk("R6", "oh_idx", oh_idx, e_idx);
        if (e_idx < 5) chk("R6", "placeholder", oh_byte, e_byte);
        else chk(s_sel[8 - e_idx] ? "R3" : "R2", "oh_byte", oh_byte, e_byte);
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en <= 1'b1; wr_addr <= a; wr_data <= d;
    @(negedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic pulse_sof();
    @(negedge clk);
    sof <= 1'b1;
    @(negedge clk);
    sof <= 1'b0;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst <= 1'b0;
    @(negedge clk);
    // R1: reset state at the ports
    chk("R1", "reset poh_clk", poh_clk, 0);
    chk("R1", "reset poh_en", poh_en, 0);
    chk("R1", "reset poh_frm", poh_frm, 0);
    chk("R1", "reset oh_valid", oh_valid, 0);
    // R1: frame before any write -> zeros
    pulse_sof();
    tick(150);
    // R2: software values, bad address ignored
    wr(3'd1, 8'hA1); wr(3'd2, 8'hB2); wr(3'd3, 8'hC3); wr(3'd4, 8'hD4);
    wr(3'd6, 8'hEE); wr(3'd0, 8'h00);
    pulse_sof();
    tick(40);
    // R7: mid-sequence config change; R8: stray sof ignored
    wr(3'd0, 8'h0F);
    wr(3'd3, 8'h77);
    pulse_sof();
    tick(110);
    // R3: all serial (config from the write above)
    pulse_sof();
    tick(150);
    // R2/R3: mixed patterns
    wr(3'd0, 8'h05);
    pulse_sof();
    tick(150);
    wr(3'd0, 8'h0A);
    pulse_sof();
    tick(150);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
    $finish;
  end
endmodule